// File: doc/BRIEF.md
# Two-Wire Streamed Line Encoder

This block sits beside the two-wire serial slave of a contactless transponder front end and drives the coil damping control. Normally the damping output simply follows a direct modulation input from the host controller. A START on the bus followed by a special control byte starts an encoder session. The byte chooses one of two line codes. For the rest of the session, each SCL pulse carries one data bit, whose value is on SDA. The chosen encoder turns that bit stream into a two-level code on the damping output: a 1 damps the coil and a 0 leaves it undamped.

A session has no byte framing. After the single acknowledge slot that follows the control byte, bits flow without pause until STOP. A START in mid-session closes it and begins a new control-byte reception. While a session owns the output, the `sessionActive` flag tells the neighbouring memory slave to stay off the bus. All bus lines are sampled on the system clock and are expected to be already synchronised.

Top module: `serial_line_encoder`

## Requirements
- R1: After reset, `sessionActive` is 0 and `dampOut` equals `directMod`.
- R2: While `sessionActive` is 0, `dampOut` equals `directMod` in the same cycle.
- R3: A control byte, received MSB first after START with one bit taken on each SCL rise, opens a session only if it has the form 110s_x111. The s bit (bit 4) selects the code: 0 for Biphase, 1 for Manchester. Bit 3 is ignored. Any other byte leaves `sessionActive` at 0 until the next START.
- R4: The ninth SCL pulse after START is an acknowledge slot. `sessionActive` is 1 during that slot, and `dampOut` stays 0 through it.
- R5: In Manchester mode, the high phase of a bit's SCL pulse carries the bit value on `dampOut` and the low phase that follows carries its inverse. A 1 is therefore high-then-low and a 0 is low-then-high.
- R6: In Biphase mode, the level starts at 0 when the session opens. It toggles on every SCL rise, and toggles again on the following SCL fall only when the bit is 0.
- R7: Data bits are encoded continuously for as long as the session lasts. No slot is skipped after every eight bits.
- R8: A STOP (SDA rising while SCL is high) clears `sessionActive` one clock later and returns `dampOut` to `directMod`. It also resets the Biphase level to 0.
- R9: A START (SDA falling while SCL is high) during a session closes the session and restarts control-byte reception.
- R10: While `sessionActive` is 1, `directMod` has no effect on `dampOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised bus clock line |
| sdaIn | input | 1 | Synchronised bus data line |
| directMod | input | 1 | Damping level used outside a session |
| dampOut | output | 1 | Coil damping control, 1 = damped |
| sessionActive | output | 1 | The encoder owns the damping output |

## Verification
Each bus event is decoded from the current sample of the lines against a one-clock-old copy. As a result, an SCL or SDA change seen at a clock edge updates `dampOut` and `sessionActive` at that same edge. The passthrough path from `directMod` is combinational. The bench changes the lines on a falling clock edge and samples one full clock later, at the next falling edge. Every half-bit level, the acknowledge slot and the state after STOP and START are therefore checked exactly one register stage after their cause. The bench sweeps all 256 control bytes and every 4-bit seed pattern under both codes.

// File: rtl/lineenc_pkg.sv
package lineenc_pkg;
  parameter int unsigned CTRL_W = 8;
  parameter logic [CTRL_W-1:0] MATCH_MASK = 8'b1110_0111;
  parameter logic [CTRL_W-1:0] MATCH_VAL  = 8'b1100_0111;
  parameter int unsigned SEL_BIT = 4;

  typedef enum logic {CODE_BIPHASE = 1'b0, CODE_MANCH = 1'b1} code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_ACK, S_RUN, S_SKIP
  } ctl_state_e;

  typedef struct packed {
    logic clear;
    logic takeBit;
    logic halfBit;
  } strobe_t;
endpackage

// File: rtl/lineenc_ctrl.sv
module lineenc_ctrl
  import lineenc_pkg::*;
#(
  parameter int unsigned BYTE_W = CTRL_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output strobe_t stb,
  output code_e   codeSel,
  output logic    sessionActive
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  ctl_state_e state;
  logic sclQ, sdaQ, haveBit;
  logic [BYTE_W-2:0] shiftQ;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] ctrlWord;
  logic startCond, stopCond, sclRise, sclFall;

  always_comb begin
    startCond   = sclIn & sclQ & sdaQ & ~sdaIn;
    stopCond    = sclIn & sclQ & ~sdaQ & sdaIn;
    sclRise     = sclIn & ~sclQ;
    sclFall     = ~sclIn & sclQ;
    ctrlWord    = {shiftQ, sdaIn};
    stb.clear   = startCond | stopCond;
    stb.takeBit = (state == S_RUN) & sclRise;
    stb.halfBit = (state == S_RUN) & sclFall & haveBit;
  end

  assign sessionActive = (state == S_ACK) || (state == S_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      shiftQ  <= '0;
      cnt     <= '0;
      haveBit <= 1'b0;
      codeSel <= CODE_BIPHASE;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startCond) begin
        state   <= S_CTRL;
        cnt     <= '0;
        haveBit <= 1'b0;
      end else if (stopCond) begin
        state   <= S_IDLE;
        haveBit <= 1'b0;
      end else begin
        case (state)
          S_CTRL: if (sclRise) begin
            shiftQ <= ctrlWord[BYTE_W-2:0];
            if (cnt == LAST) begin
              cnt <= '0;
              if ((ctrlWord & MATCH_MASK) == MATCH_VAL) begin
                state   <= S_ACK;
                codeSel <= code_e'(ctrlWord[SEL_BIT]);
              end else begin
                state <= S_SKIP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ACK: if (sclRise) state <= S_RUN;
          S_RUN: begin
            if (stb.takeBit) haveBit <= 1'b1;
            else if (stb.halfBit) haveBit <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lineenc_dp.sv
module lineenc_dp
  import lineenc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sdaIn,
  input  logic    directMod,
  input  strobe_t stb,
  input  code_e   codeSel,
  input  logic    sessionActive,
  output logic    dampOut
);
  logic level, heldBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level   <= 1'b0;
      heldBit <= 1'b0;
    end else if (stb.clear) begin
      level <= 1'b0;
    end else if (stb.takeBit) begin
      heldBit <= sdaIn;
      level   <= (codeSel == CODE_MANCH) ? sdaIn : ~level;
    end else if (stb.halfBit) begin
      if (codeSel == CODE_MANCH) level <= ~heldBit;
      else if (!heldBit)         level <= ~level;
    end
  end

  assign dampOut = sessionActive ? level : directMod;
endmodule

// File: rtl/serial_line_encoder.sv
module serial_line_encoder
  import lineenc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic directMod,
  output logic dampOut,
  output logic sessionActive
);
  strobe_t stb;
  code_e   codeSel;

  lineenc_ctrl #(.BYTE_W(CTRL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stb(stb), .codeSel(codeSel), .sessionActive(sessionActive)
  );

  lineenc_dp u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .directMod(directMod),
    .stb(stb), .codeSel(codeSel), .sessionActive(sessionActive),
    .dampOut(dampOut)
  );
endmodule

// File: rtl/lineenc_chk.sv
module lineenc_chk
  import lineenc_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sclIn,
  input logic    sdaIn,
  input logic    directMod,
  input logic    dampOut,
  input logic    sessionActive,
  input strobe_t stb,
  input code_e   codeSel
);
  logic sclP, sdaP, bitP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
      bitP <= 1'b0;
    end else begin
      sclP <= sclIn;
      sdaP <= sdaIn;
      if (stb.takeBit) bitP <= sdaIn;
    end
  end

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sessionActive |-> dampOut == directMod);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && sclP && !sdaP && sdaIn) |=> !sessionActive);

  p_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && sclP && sdaP && !sdaIn) |=> !sessionActive);

  p_manch_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeBit && codeSel == CODE_MANCH) |=> dampOut == $past(sdaIn));

  p_manch_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.halfBit && codeSel == CODE_MANCH) |=> dampOut != $past(dampOut));

  p_bi_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeBit && codeSel == CODE_BIPHASE) |=> dampOut != $past(dampOut));

  p_bi_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.halfBit && codeSel == CODE_BIPHASE) |=> dampOut == ($past(dampOut) ^ !bitP));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sessionActive && !stb.takeBit && !stb.halfBit && !stb.clear)
      |=> ($stable(dampOut) || !sessionActive));

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeBit, stb.halfBit}));
endmodule

bind serial_line_encoder lineenc_chk u_chk (.*);

// File: tb/serial_line_encoder_test.sv
module serial_line_encoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic directMod = 1'b0;
  logic dampOut, sessionActive;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic modelLvl = 1'b0;
  bit   modelManch = 1'b0;

  always #5 clk = ~clk;

  serial_line_encoder uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .directMod(directMod), .dampOut(dampOut), .sessionActive(sessionActive)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic scl, input logic sda);
    @(negedge clk);
    sclIn = scl;
    sdaIn = sda;
    @(negedge clk);
  endtask

  task automatic busStart();
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    modelLvl = 1'b0;
  endtask

  task automatic busStop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    modelLvl = 1'b0;
  endtask

  task automatic rawBit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
  endtask

  // one data bit with both half-bit levels checked against the model
  task automatic dataBit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
    modelLvl = modelManch ? b : ~modelLvl;
    chk(modelManch ? "R5 high half" : "R6 rise toggle", dampOut, modelLvl);
    drive(1'b0, b);
    if (modelManch) modelLvl = ~b;
    else if (!b)    modelLvl = ~modelLvl;
    chk(modelManch ? "R5 low half" : "R6 mid-bit", dampOut, modelLvl);
  endtask

  task automatic ctrlByte(input logic [7:0] cb);
    for (int i = 7; i >= 0; i--) rawBit(cb[i]);
  endtask

  task automatic ackSlot();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    chk("R4 ack active", sessionActive, 1'b1);
    chk("R4 ack high", dampOut, 1'b0);
    drive(1'b0, 1'b0);
    chk("R4 ack low", dampOut, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset active", sessionActive, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle active", sessionActive, 1'b0);
    chk("R1 idle out", dampOut, 1'b0);
    directMod = 1'b1;
    @(negedge clk);
    chk("R2 passthrough", dampOut, 1'b1);

    // R3: every control byte
    for (int cb = 0; cb < 256; cb++) begin
      logic [7:0] b8;
      bit hit;
      b8 = 8'(cb);
      hit = (b8[7:5] == 3'b110) && (b8[2:0] == 3'b111);
      busStart();
      ctrlByte(b8);
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      chk("R3 decode", sessionActive, hit);
      if (!hit) begin
        directMod = b8[0];
        @(negedge clk);
        chk("R3 non-match passthrough", dampOut, b8[0]);
      end
      drive(1'b0, 1'b0);
      busStop();
      chk("R8 stop ends", sessionActive, 1'b0);
    end

    // R5/R6/R7: sweeps of streamed bits for both codes and both don't-care values
    for (int code = 0; code < 2; code++) begin
      for (int x = 0; x < 2; x++) begin
        for (int p = 0; p < 16; p++) begin
          logic [11:0] stream;
          stream = {4'(p), ~4'(p), 4'(p)};
          modelManch = (code == 1);
          busStart();
          ctrlByte({3'b110, 1'(code), 1'(x), 3'b111});
          ackSlot();
          for (int i = 11; i >= 0; i--) begin
            directMod = ~directMod;   // R10: must not disturb the code
            dataBit(stream[i]);
          end
          busStop();
          chk("R8 stop active", sessionActive, 1'b0);
          directMod = 1'b0;
          @(negedge clk);
          chk("R8 back to direct 0", dampOut, 1'b0);
          directMod = 1'b1;
          @(negedge clk);
          chk("R8 back to direct 1", dampOut, 1'b1);
        end
      end
    end

    // R9: START inside a session, then a fresh session with the other code
    for (int code = 0; code < 2; code++) begin
      modelManch = (code == 1);
      busStart();
      ctrlByte({3'b110, 1'(code), 4'b0111});
      ackSlot();
      dataBit(1'b0);
      dataBit(1'b1);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
      chk("R9 restart closes", sessionActive, 1'b0);
      chk("R9 restart passthrough", dampOut, directMod);
      drive(1'b0, 1'b0);
      modelLvl = 1'b0;
      modelManch = (code == 0);
      ctrlByte({3'b110, 1'(code == 0), 4'b1111});
      ackSlot();
      for (int i = 0; i < 10; i++) dataBit(1'((i * 3 + 1) % 2));
      busStop();
      chk("R9 final stop", sessionActive, 1'b0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule